// File: doc/BRIEF.md
# SPI Controller with Mode Fault

This block is a byte-wide serial peripheral controller that runs either as the clock-driving master or as a slave clocked from outside. A small register port, with a control register, a status register and a data register, lets software pick the mode and one of four serial clock rates, queue a byte to send and read back the byte received. The serial clock idles low. A bit is sampled on each rising edge and the next bit is shifted out on each falling edge. Frames are eight bits long, most significant bit first.

Mode-fault logic watches the slave-select input. When a master has the fault check switched on and the select line is pulled low, the block drops out of master mode, aborts the frame, releases its clock and data outputs and raises a sticky fault flag. Only a status read followed by a control write clears that flag. A single output tells the pad logic whether the select pin is free for general-purpose use. A transmit-empty interrupt request is also provided.

Top module: `spi_mf_ctrl`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x01 (bit 0 transmit-empty = 1, bit 1 mode fault = 0), the serial clock output is low and irq is low.
- R2: A write to the data register (address 2) clears transmit-empty on that clock edge. The byte moves into the shifter on the next edge if the shifter is idle and the block is enabled (control bit 0), and transmit-empty is then set again. A byte written while a frame is in progress stays pending, with transmit-empty low, until that frame ends.
- R3: In master mode the rate field (control bits 5:4) values 0, 1, 2 and 3 give half-periods of 2, 8, 32 and 128 input clocks, so one serial clock period is twice the divisor. The serial clock stays low while no frame runs.
- R4: A master frame drives the serial clock for eight cycles and presents the transmit byte on mosi_out most significant bit first. It samples miso_in on each rising edge, and a read of the data register then returns the eight sampled bits.
- R5: The mode-fault flag (status bit 1) can be set only while mode-fault enable (control bit 3) is 1. Clearing the enable bit leaves an already-set flag at 1.
- R6: The fault flag is cleared only by a control write that follows a status read made while the flag was set. A control write without that read leaves it set.
- R7: In master mode (control bit 1 = 1) with fault enable set, a low ss_in sets the flag, clears the master bit, aborts the frame, and drives sclk_oe and mosi_oe low with sclk_out low.
- R8: ss_gpio is 1 when the block is disabled or is a master with fault enable 0, and 0 otherwise. In a master with fault enable 0 the ss_in level has no effect on a frame.
- R9: irq equals transmit-empty AND interrupt enable (control bit 2).
- R10: An enabled slave (control bit 1 = 0) ignores the rate field. While ss_in is low it samples mosi_in on each rising edge of sclk_in and shifts its byte out on miso_out, most significant bit first, with miso_oe high. After eight bits the received byte is readable at the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data appears on bus_rdata after the edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Transmit-empty interrupt request |
| ss_in | input | 1 | Slave-select pin level |
| ss_gpio | output | 1 | High when the slave-select pin is free for general-purpose use |
| sclk_in | input | 1 | Serial clock from an external master |
| sclk_out | output | 1 | Serial clock driven as master |
| sclk_oe | output | 1 | Output enable for sclk_out |
| mosi_in | input | 1 | Serial data in as slave |
| mosi_out | output | 1 | Serial data out as master |
| mosi_oe | output | 1 | Output enable for mosi_out |
| miso_in | input | 1 | Serial data in as master |
| miso_out | output | 1 | Serial data out as slave |
| miso_oe | output | 1 | Output enable for miso_out |

## Verification
The hardest state to reach is a mode fault that lands in the middle of a master frame, followed by the two-step clear. The stimulus starts a slow frame, pulls ss_in low twenty cycles in, and checks the released outputs and the cleared master bit. It then writes the control register before any status read, to show the flag is sticky while the enable is off. Only after that does it read status and write control again to clear the flag. Back-to-back writes at the slower rates keep a byte pending behind a busy shifter, and an inverted loopback proves that received data comes from miso_in and not from the transmit byte.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  localparam int RATE_W = 2;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  // control register: bit 0 enable, bit 1 master, bit 2 irq enable,
  // bit 3 mode-fault enable, bits 5:4 rate select
  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              mfen;
    logic              tie;
    logic              mstr;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/spi_mf_baud.sv
module spi_mf_baud #(
  parameter int SEL_W      = 2,
  parameter int BASE_SHIFT = 1,
  parameter int STEP_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] rate,
  output logic             sclk,
  output logic             sample_str,
  output logic             shift_str
);
  localparam int N_RATES = 1 << SEL_W;
  localparam int MAX_DIV = 1 << (BASE_SHIFT + STEP_SHIFT * (N_RATES - 1));
  localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;

  logic [CNT_W-1:0] lim [N_RATES];
  logic [CNT_W-1:0] cnt;
  logic             tick;

  // geometric divisor table, one entry per rate code
  for (genvar g = 0; g < N_RATES; g++) begin : g_rate
    localparam int DIV = 1 << (BASE_SHIFT + STEP_SHIFT * g);
    assign lim[g] = CNT_W'(DIV - 1);
  end

  assign tick       = run & (cnt >= lim[rate]);
  assign sample_str = tick & ~sclk;
  assign shift_str  = tick & sclk;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else if (tick) begin
      cnt  <= '0;
      sclk <= ~sclk;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> !sclk);
endmodule

// File: rtl/spi_mf_shifter.sv
module spi_mf_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         abort,
  input  logic         load,
  input  logic [W-1:0] ld_data,
  input  logic         sample_str,
  input  logic         shift_str,
  input  logic         bit_in,
  output logic         busy,
  output logic         ser_out,
  output logic [W-1:0] rx_data
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  shreg;
  logic          samp;
  logic [CW-1:0] cnt;

  assign ser_out = shreg[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      samp    <= 1'b0;
      cnt     <= '0;
      busy    <= 1'b0;
      rx_data <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (load && !busy) begin
      shreg <= ld_data;
      busy  <= 1'b1;
      cnt   <= '0;
    end else if (busy) begin
      if (sample_str && cnt != CW'(W)) begin
        samp <= bit_in;
        cnt  <= cnt + 1'b1;
      end else if (shift_str && cnt != '0) begin
        if (cnt == CW'(W)) begin
          busy    <= 1'b0;
          cnt     <= '0;
          rx_data <= {shreg[W-2:0], samp};
        end else begin
          shreg <= {shreg[W-2:0], samp};
        end
      end
    end
  end

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= CW'(W)));
endmodule

// File: rtl/spi_mf_ctrl.sv
module spi_mf_ctrl
  import spi_mf_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BASE_SHIFT  = 1,
  parameter int STEP_SHIFT  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  input  logic              ss_in,
  output logic              ss_gpio,
  input  logic              sclk_in,
  output logic              sclk_out,
  output logic              sclk_oe,
  input  logic              mosi_in,
  output logic              mosi_out,
  output logic              mosi_oe,
  input  logic              miso_in,
  output logic              miso_out,
  output logic              miso_oe
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic              mf_flag, clr_armed, tx_empty;
  logic [DATA_W-1:0] txbuf, rx_byte;
  logic [SYNC_STAGES-1:0] ss_sr, sck_sr, mosi_sr;
  logic              sck_d;
  logic              ss_s, sck_s, mosi_s;
  logic              wr_ctrl, wr_data, rd_stat;
  logic              fault_set, abort, load, sh_busy, sh_out;
  logic              m_run, m_sclk, m_sample, m_shift;
  logic              sl_act, sample_str, shift_str, bit_in;

  assign wr_ctrl = bus_wr & (bus_addr == A_CTRL);
  assign wr_data = bus_wr & (bus_addr == A_DATA);
  assign rd_stat = bus_rd & (bus_addr == A_STAT);

  // input synchronisers
  always_ff @(posedge clk) begin
    if (rst) begin
      ss_sr   <= '1;
      sck_sr  <= '0;
      mosi_sr <= '0;
      sck_d   <= 1'b0;
    end else begin
      ss_sr   <= {ss_sr[SYNC_STAGES-2:0], ss_in};
      sck_sr  <= {sck_sr[SYNC_STAGES-2:0], sclk_in};
      mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi_in};
      sck_d   <= sck_s;
    end
  end
  assign ss_s   = ss_sr[SYNC_STAGES-1];
  assign sck_s  = sck_sr[SYNC_STAGES-1];
  assign mosi_s = mosi_sr[SYNC_STAGES-1];

  assign fault_set = ctrl_q.en & ctrl_q.mstr & ctrl_q.mfen & ~ss_s;
  assign abort     = fault_set | ~ctrl_q.en;
  assign load      = ~tx_empty & ~sh_busy & ctrl_q.en & ~abort;

  // register file, fault flag and transmit holding register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      mf_flag   <= 1'b0;
      clr_armed <= 1'b0;
      tx_empty  <= 1'b1;
      txbuf     <= '0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (fault_set) ctrl_q.mstr <= 1'b0;

      if (fault_set) mf_flag <= 1'b1;
      else if (wr_ctrl && clr_armed) mf_flag <= 1'b0;

      if (wr_ctrl) clr_armed <= 1'b0;
      else if (rd_stat && mf_flag) clr_armed <= 1'b1;

      if (wr_data) begin
        txbuf    <= bus_wdata;
        tx_empty <= 1'b0;
      end else if (load) begin
        tx_empty <= 1'b1;
      end

      if (bus_rd) begin
        case (bus_addr)
          A_CTRL:  bus_rdata <= DATA_W'(ctrl_q);
          A_STAT:  bus_rdata <= DATA_W'({mf_flag, tx_empty});
          A_DATA:  bus_rdata <= rx_byte;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  assign m_run = sh_busy & ctrl_q.en & ctrl_q.mstr;

  spi_mf_baud #(
    .SEL_W(RATE_W), .BASE_SHIFT(BASE_SHIFT), .STEP_SHIFT(STEP_SHIFT)
  ) u_baud (
    .clk(clk), .rst(rst), .run(m_run), .rate(ctrl_q.rate),
    .sclk(m_sclk), .sample_str(m_sample), .shift_str(m_shift)
  );

  assign sl_act     = ctrl_q.en & ~ctrl_q.mstr & ~ss_s;
  assign sample_str = ctrl_q.mstr ? m_sample : (sl_act & sck_s & ~sck_d);
  assign shift_str  = ctrl_q.mstr ? m_shift  : (sl_act & ~sck_s & sck_d);
  assign bit_in     = ctrl_q.mstr ? miso_in : mosi_s;

  spi_mf_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .abort(abort), .load(load), .ld_data(txbuf),
    .sample_str(sample_str), .shift_str(shift_str), .bit_in(bit_in),
    .busy(sh_busy), .ser_out(sh_out), .rx_data(rx_byte)
  );

  assign irq      = tx_empty & ctrl_q.tie;
  assign ss_gpio  = ~ctrl_q.en | (ctrl_q.mstr & ~ctrl_q.mfen);
  assign sclk_out = m_sclk;
  assign sclk_oe  = ctrl_q.en & ctrl_q.mstr;
  assign mosi_out = sh_out;
  assign mosi_oe  = ctrl_q.en & ctrl_q.mstr;
  assign miso_out = sh_out;
  assign miso_oe  = ctrl_q.en & ~ctrl_q.mstr & ~ss_s;

  p_txe_clear_r2: assert property (@(posedge clk) disable iff (rst)
    wr_data |=> !tx_empty);

  p_mf_needs_enable_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mf_flag) |-> $past(ctrl_q.mfen));

  p_mf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(mf_flag) && !mf_flag) |-> $past(clr_armed && wr_ctrl));

  p_fault_exit_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(mf_flag) |-> (!ctrl_q.mstr && !sh_busy));
endmodule

// File: tb/spi_mf_ctrl_tb.sv
module spi_mf_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq, ss_gpio, sclk_out, sclk_oe, mosi_out, mosi_oe;
  logic       miso_out, miso_oe, miso_in;
  logic       ss_in = 1'b1, sclk_in = 1'b0, mosi_in = 1'b0;
  logic       loop_inv = 1'b0;

  int total = 0, bad = 0, cyc = 0;
  logic mdl_on = 1'b0;

  always #2 clk = ~clk;

  assign miso_in = loop_inv ? ~mosi_out : mosi_out;

  spi_mf_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .ss_in(ss_in),
    .ss_gpio(ss_gpio), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .mosi_in(mosi_in), .mosi_out(mosi_out), .mosi_oe(mosi_oe), .miso_in(miso_in),
    .miso_out(miso_out), .miso_oe(miso_oe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference for master mode, advanced on every rising edge
  int       m_txe = 1, m_busy = 0, m_j = 0, m_bd = 2;
  logic [5:0] m_ctrl = 6'd0;
  always @(posedge clk) begin
    if (rst) begin
      m_txe = 1; m_busy = 0; m_j = 0; m_ctrl = 6'd0;
    end else begin
      int ld;
      ld = (m_txe == 0 && m_busy == 0 && m_ctrl[0]) ? 1 : 0;
      m_bd = 2 << (2 * int'(m_ctrl[5:4]));
      if (!m_ctrl[0]) begin
        m_busy = 0; m_j = 0;
      end else if (m_busy != 0) begin
        m_j++;
        if (m_j == 16 * m_bd) m_busy = 0;
      end
      if (ld != 0) begin m_busy = 1; m_j = 0; m_txe = 1; end
      if (bus_wr && bus_addr == 2'd2) m_txe = 0;
      if (bus_wr && bus_addr == 2'd0) m_ctrl = bus_wdata[5:0];
    end
  end

  // per-clock comparison and serial line capture
  logic [7:0] cap = 8'd0;
  logic       prev_sclk = 1'b0;
  int         hi_run = 0, last_hi = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (mdl_on) begin
        int bd;
        bd = 2 << (2 * int'(m_ctrl[5:4]));
        check("R9 irq per clock", int'(irq), (m_txe != 0 && m_ctrl[2]) ? 1 : 0);
        check("R3 sclk per clock", int'(sclk_out),
              (m_busy != 0 && ((m_j / bd) % 2) == 1) ? 1 : 0);
      end
      if (sclk_out && !prev_sclk) cap = {cap[6:0], mosi_out};
      if (sclk_out) hi_run++;
      else if (prev_sclk) begin last_hi = hi_run; hi_run = 0; end
      prev_sclk = sclk_out;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rate_frame(input logic [7:0] cv, input int bd, input logic [7:0] d);
    logic [7:0] v;
    wr(2'd0, cv);
    wr(2'd2, d);
    wait_cyc(16 * bd + 6);
    rd(2'd2, v);
    check("R4 rx at rate", int'(v), int'(d));
    check("R3 half period", last_hi, bd);
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] scap;
    wait_cyc(4);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, v); check("R1 ctrl", int'(v), 0);
    rd(2'd1, v); check("R1 status", int'(v), 1);
    check("R1 irq", int'(irq), 0);
    check("R1 sclk", int'(sclk_out), 0);
    check("R8 disabled gpio", int'(ss_gpio), 1);
    mdl_on = 1'b1;

    // master, fastest rate, irq enabled, straight loopback
    wr(2'd0, 8'h07);
    check("R9 irq on", int'(irq), 1);
    check("R8 master no fault gpio", int'(ss_gpio), 1);
    wr(2'd2, 8'hA5);
    wait_cyc(16 * 2 + 4);
    rd(2'd2, v); check("R4 rx loopback", int'(v), 8'hA5);
    check("R4 msb first", int'(cap), 8'hA5);
    check("R3 half period rate0", last_hi, 2);

    // R2 pending byte behind busy shifter, inverted loopback, irq off
    wr(2'd0, 8'h13);
    check("R9 irq off", int'(irq), 0);
    loop_inv = 1'b1;
    wr(2'd2, 8'h3C);
    wr(2'd2, 8'hC3);
    rd(2'd1, v); check("R2 pending txe", int'(v), 0);
    wait_cyc(2 * 16 * 8 + 10);
    rd(2'd1, v); check("R2 txe set again", int'(v), 1);
    rd(2'd2, v); check("R2 second byte rx", int'(v), 8'h3C);
    check("R4 msb first second", int'(cap), 8'hC3);
    check("R3 half period rate1", last_hi, 8);
    loop_inv = 1'b0;

    rate_frame(8'h23, 32, 8'h5A);
    rate_frame(8'h33, 128, 8'h69);

    // R8 ss level ignored by master without fault check
    wr(2'd0, 8'h03);
    ss_in = 1'b0;
    wr(2'd2, 8'hE1);
    wait_cyc(16 * 2 + 6);
    rd(2'd2, v); check("R8 frame with ss low", int'(v), 8'hE1);
    rd(2'd1, v); check("R5 no flag when disabled", int'(v), 1);
    check("R8 gpio still free", int'(ss_gpio), 1);
    ss_in = 1'b1;
    wait_cyc(4);
    mdl_on = 1'b0;

    // R7 mode fault mid-frame
    wr(2'd0, 8'h1F);
    check("R8 master with fault check gpio", int'(ss_gpio), 0);
    wr(2'd2, 8'h77);
    wait_cyc(20);
    ss_in = 1'b0;
    wait_cyc(5);
    check("R7 sclk_oe released", int'(sclk_oe), 0);
    check("R7 mosi_oe released", int'(mosi_oe), 0);
    check("R7 sclk low", int'(sclk_out), 0);
    rd(2'd0, v); check("R7 master bit cleared", int'(v), 8'h1D);
    wr(2'd0, 8'h15);
    rd(2'd1, v); check("R5 flag sticky after enable cleared", int'(v), 3);
    ss_in = 1'b1;
    wait_cyc(4);
    wr(2'd0, 8'h15);
    rd(2'd1, v); check("R6 flag cleared by sequence", int'(v), 1);

    // R10 slave transfer, rate field set but ignored
    wr(2'd0, 8'h31);
    check("R8 slave gpio", int'(ss_gpio), 0);
    wr(2'd2, 8'h96);
    ss_in = 1'b0;
    wait_cyc(4);
    check("R10 miso_oe", int'(miso_oe), 1);
    check("R10 sclk_oe off", int'(sclk_oe), 0);
    scap = 8'd0;
    for (int i = 7; i >= 0; i--) begin
      mosi_in = 8'h5B >> i;
      wait_cyc(6);
      scap = {scap[6:0], miso_out};
      sclk_in = 1'b1;
      wait_cyc(6);
      sclk_in = 1'b0;
    end
    wait_cyc(8);
    rd(2'd2, v); check("R10 slave rx", int'(v), 8'h5B);
    check("R10 slave tx msb first", int'(scap), 8'h96);
    ss_in = 1'b1;
    wait_cyc(4);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule